// File: doc/BRIEF.md
# GPIO Port with Edge-Select Interrupts

A 32-pin general-purpose I/O port, reached through a simple word-wide register bus. Each pin is driven from a data register when its direction bit marks it as an output. Each pin's input is synchronised and fed to its own trigger detector. A detector can fire on low level, high level, rising edge or falling edge. A per-pin edge-select bit overrides the chosen trigger and fires on every transition. Detected events land in sticky status bits. Software clears a status bit by writing 1 to it. The masked status bits are ORed into a single interrupt line.

Writes take effect at the clock edge on which `wrEn` is sampled high. Reads are combinational from `addr`. A build parameter drops the edge-select register. That gives the older variant, in which only the 2-bit trigger codes apply.

Top module: `gpio_edge_port`

## Requirements
- R1: While reset is asserted and right after it, every register reads zero, `padOut` and `padOe` are zero and `irqOut` is low. So every pin is an input, uses trigger code 00 and is masked.
- R2: The byte offsets are: data 0x00, direction 0x04, pad status 0x08, low trigger config 0x0C, high trigger config 0x10, mask 0x14, status 0x18 and edge select 0x1C. A register written at one clock edge reads back its value after that edge. `padOut` equals the data register and `padOe` equals the direction register (1 drives the pin). An access whose two low address bits are not zero writes nothing and reads zero.
- R3: The pad status register returns `padIn` delayed by a two-flop synchroniser. A pad change driven before clock edge k is readable after edge k+1.
- R4: Pin p takes its 2-bit trigger code from bits [2(p mod 16)+1 : 2(p mod 16)]. Pins 0–15 use the register at 0x0C and pins 16–31 use the register at 0x10. The codes are 00 low level, 01 high level, 10 rising edge and 11 falling edge.
- R5: When a pin's bit in the edge-select register (0x1C) is 1, its status bit is set on every rising and every falling transition, and its trigger code has no effect.
- R6: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R7: A level-triggered status bit is set again on every cycle that its level holds, so a clear shows no lasting effect. An edge-triggered status bit stays set until it is cleared.
- R8: When a set event and a write-1 clear reach the same status bit in the same cycle, the bit ends up set.
- R9: `irqOut` is the OR of status AND mask. Status bits are set whatever the mask holds.
- R10: With `HAS_EDGE_SEL` = 0, offset 0x1C reads zero, writes to it are ignored, and only the 2-bit codes select triggers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe for the register at `addr` |
| addr | input | 5 | Byte offset of the register |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for `addr`, combinational |
| padIn | input | 32 | Pad input levels, asynchronous |
| padOut | output | 32 | Pad output values |
| padOe | output | 32 | Pad output enables |
| irqOut | output | 1 | Combined interrupt request |

## Verification
Register writes are observed one edge after the write and pad status two edges after a pad change. A status bit is due three edges after a pad change: two synchroniser stages and the status register. The interrupt line follows status and mask with no further delay. The bench drives stimulus on falling edges and counts falling edges to reach exactly those points before it samples. Near-exhaustive runs sweep every uniform trigger code, a mixed per-pin code layout, and several edge-select patterns over two pad transitions. For each pin the bench computes the expected status from the code, the edge-select bit and the two pad words. The set-versus-clear collision is timed so that the write lands on the same edge as the third stage of the pad change. The same sweeps check the variant without edge select, with edge select forced to zero in the expected values.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  localparam int ADDR_W = 5;
  localparam int SEL_W  = ADDR_W - 2;

  typedef enum logic [1:0] {
    TRIG_LOW  = 2'b00,
    TRIG_HIGH = 2'b01,
    TRIG_RISE = 2'b10,
    TRIG_FALL = 2'b11
  } trigCode_e;

  typedef enum logic [SEL_W-1:0] {
    SEL_DATA  = 3'd0,
    SEL_DIR   = 3'd1,
    SEL_PAD   = 3'd2,
    SEL_CFGLO = 3'd3,
    SEL_CFGHI = 3'd4,
    SEL_MASK  = 3'd5,
    SEL_STAT  = 3'd6,
    SEL_EDGE  = 3'd7
  } regSel_e;

  typedef struct packed {
    logic wrData;
    logic wrDir;
    logic wrCfgLo;
    logic wrCfgHi;
    logic wrMask;
    logic wrClear;
    logic wrEdge;
  } regStrobe_t;

endpackage

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
  import gpio_pkg::*;
#(
  parameter bit HAS_EDGE_SEL = 1'b1
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output regStrobe_t        strobe,
  output regSel_e           rdSel,
  output logic              rdHit
);

  logic aligned;

  assign aligned = (addr[1:0] == 2'b00);
  assign rdSel   = regSel_e'(addr[ADDR_W-1:2]);
  assign rdHit   = aligned;

  always_comb begin
    strobe = '0;
    if (wrEn && aligned) begin
      unique case (rdSel)
        SEL_DATA:  strobe.wrData  = 1'b1;
        SEL_DIR:   strobe.wrDir   = 1'b1;
        SEL_PAD:   ;
        SEL_CFGLO: strobe.wrCfgLo = 1'b1;
        SEL_CFGHI: strobe.wrCfgHi = 1'b1;
        SEL_MASK:  strobe.wrMask  = 1'b1;
        SEL_STAT:  strobe.wrClear = 1'b1;
        SEL_EDGE:  strobe.wrEdge  = HAS_EDGE_SEL;
        default:   ;
      endcase
    end
  end

endmodule

// File: rtl/gpio_edge_trig.sv
module gpio_edge_trig
  import gpio_pkg::*;
(
  input  logic [1:0] code,
  input  logic       anyEdge,
  input  logic       cur,
  input  logic       prev,
  output logic       hit
);

  always_comb begin
    if (anyEdge) begin
      hit = cur ^ prev;
    end else begin
      unique case (trigCode_e'(code))
        TRIG_LOW:  hit = ~cur;
        TRIG_HIGH: hit = cur;
        TRIG_RISE: hit = cur & ~prev;
        TRIG_FALL: hit = ~cur & prev;
        default:   hit = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/gpio_edge_dp.sv
module gpio_edge_dp
  import gpio_pkg::*;
#(
  parameter int DATA_W       = 32,
  parameter bit HAS_EDGE_SEL = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strobe,
  input  logic [DATA_W-1:0] wrData,
  input  regSel_e           rdSel,
  input  logic              rdHit,
  input  logic [DATA_W-1:0] padIn,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] padOut,
  output logic [DATA_W-1:0] padOe,
  output logic              irqOut
);

  localparam int HALF   = DATA_W / 2;
  localparam int CODE_W = 2;

  logic [DATA_W-1:0] dataQ, dirQ, cfgLoQ, cfgHiQ, maskQ, statusQ, edgeQ;
  logic [DATA_W-1:0] syncA, syncB, prevQ;
  logic [DATA_W-1:0] hits, clearMask, statusNext;

  // software-visible configuration
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataQ  <= '0;
      dirQ   <= '0;
      cfgLoQ <= '0;
      cfgHiQ <= '0;
      maskQ  <= '0;
    end else begin
      if (strobe.wrData)  dataQ  <= wrData;
      if (strobe.wrDir)   dirQ   <= wrData;
      if (strobe.wrCfgLo) cfgLoQ <= wrData;
      if (strobe.wrCfgHi) cfgHiQ <= wrData;
      if (strobe.wrMask)  maskQ  <= wrData;
    end
  end

  if (HAS_EDGE_SEL) begin : g_edgeReg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              edgeQ <= '0;
      else if (strobe.wrEdge) edgeQ <= wrData;
    end
  end else begin : g_noEdgeReg
    assign edgeQ = '0;
  end

  // two-flop synchroniser plus one stage of history for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
      prevQ <= '0;
    end else begin
      syncA <= padIn;
      syncB <= syncA;
      prevQ <= syncB;
    end
  end

  for (genvar p = 0; p < DATA_W; p++) begin : g_pin
    logic [CODE_W-1:0] code;
    if (p < HALF) begin : g_lo
      assign code = cfgLoQ[CODE_W*p +: CODE_W];
    end else begin : g_hi
      assign code = cfgHiQ[CODE_W*(p-HALF) +: CODE_W];
    end
    gpio_edge_trig u_trig (
      .code   (code),
      .anyEdge(edgeQ[p]),
      .cur    (syncB[p]),
      .prev   (prevQ[p]),
      .hit    (hits[p])
    );
  end

  // a set event in the same cycle as a clear wins
  assign clearMask  = strobe.wrClear ? wrData : '0;
  assign statusNext = (statusQ & ~clearMask) | hits;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) statusQ <= '0;
    else       statusQ <= statusNext;
  end

  always_comb begin
    rdData = '0;
    if (rdHit) begin
      unique case (rdSel)
        SEL_DATA:  rdData = dataQ;
        SEL_DIR:   rdData = dirQ;
        SEL_PAD:   rdData = syncB;
        SEL_CFGLO: rdData = cfgLoQ;
        SEL_CFGHI: rdData = cfgHiQ;
        SEL_MASK:  rdData = maskQ;
        SEL_STAT:  rdData = statusQ;
        SEL_EDGE:  rdData = edgeQ;
        default:   rdData = '0;
      endcase
    end
  end

  assign padOut = dataQ;
  assign padOe  = dirQ;
  assign irqOut = |(statusQ & maskQ);

endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port
  import gpio_pkg::*;
#(
  parameter int DATA_W       = 32,
  parameter bit HAS_EDGE_SEL = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic [DATA_W-1:0] padIn,
  output logic [DATA_W-1:0] padOut,
  output logic [DATA_W-1:0] padOe,
  output logic              irqOut
);

  regStrobe_t strobe;
  regSel_e    rdSel;
  logic       rdHit;

  gpio_edge_ctrl #(.HAS_EDGE_SEL(HAS_EDGE_SEL)) u_ctrl (
    .wrEn  (wrEn),
    .addr  (addr),
    .strobe(strobe),
    .rdSel (rdSel),
    .rdHit (rdHit)
  );

  gpio_edge_dp #(.DATA_W(DATA_W), .HAS_EDGE_SEL(HAS_EDGE_SEL)) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .wrData(wrData),
    .rdSel (rdSel),
    .rdHit (rdHit),
    .padIn (padIn),
    .rdData(rdData),
    .padOut(padOut),
    .padOe (padOe),
    .irqOut(irqOut)
  );

endmodule

// File: rtl/gpio_edge_port_chk.sv
module gpio_edge_port_chk
  import gpio_pkg::*;
#(
  parameter int DATA_W       = 32,
  parameter bit HAS_EDGE_SEL = 1'b1
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wrData,
  input logic [DATA_W-1:0] rdData,
  input logic [DATA_W-1:0] padIn,
  input logic [DATA_W-1:0] padOut,
  input logic [DATA_W-1:0] padOe,
  input logic              irqOut
);

  logic [1:0] upCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              upCnt <= '0;
    else if (upCnt != 2'd3) upCnt <= upCnt + 2'd1;
  end

  always @(negedge clk) begin
    if (!rstN) begin
      AST_RESET_QUIET: assert (padOut == '0 && padOe == '0 && !irqOut); // R1
    end
  end

  AST_DATA_DRIVES_PAD: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 5'h00) |=> (padOut == $past(wrData))); // R2

  AST_DIR_DRIVES_OE: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 5'h04) |=> (padOe == $past(wrData))); // R2

  AST_PAD_TWO_STAGE: assert property (@(posedge clk) disable iff (!rstN)
    (upCnt == 2'd3 && addr == 5'h08) |-> (rdData == $past(padIn, 2))); // R3

  AST_MASK_SILENCES: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 5'h14 && wrData == '0) |=> !irqOut); // R9

  if (!HAS_EDGE_SEL) begin : g_legacy
    AST_NO_EDGE_REG: assert property (@(posedge clk) disable iff (!rstN)
      (addr == 5'h1C) |-> (rdData == '0)); // R10
  end

endmodule

bind gpio_edge_port gpio_edge_port_chk #(
  .DATA_W      (DATA_W),
  .HAS_EDGE_SEL(HAS_EDGE_SEL)
) u_chk (
  .clk   (clk),
  .rstN  (rstN),
  .wrEn  (wrEn),
  .addr  (addr),
  .wrData(wrData),
  .rdData(rdData),
  .padIn (padIn),
  .padOut(padOut),
  .padOe (padOe),
  .irqOut(irqOut)
);

// File: tb/gpio_edge_port_test.sv
`timescale 1ns/1ps
module gpio_edge_port_test;

  logic        clk = 1'b0;
  logic        rstN;
  logic        wrEn;
  logic [4:0]  addr;
  logic [31:0] wrData;
  logic [31:0] padIn;
  logic [31:0] rdData, padOut, padOe;
  logic        irqOut;
  logic [31:0] rdDataL, padOutL, padOeL;
  logic        irqOutL;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  gpio_edge_port uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .padIn(padIn), .padOut(padOut), .padOe(padOe), .irqOut(irqOut)
  );

  gpio_edge_port #(.HAS_EDGE_SEL(1'b0)) uutLegacy (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdDataL), .padIn(padIn), .padOut(padOutL), .padOe(padOeL), .irqOut(irqOutL)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busWrite(input logic [4:0] a, input logic [31:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic peek(input logic [4:0] a);
    addr = a;
    #1;
  endtask

  function automatic logic [1:0] codeOf(input logic [31:0] lo, input logic [31:0] hi, input int i);
    if (i < 16) return lo[2*i +: 2];
    else        return hi[2*(i-16) +: 2];
  endfunction

  function automatic logic [31:0] lvlBits(input logic [31:0] lo, input logic [31:0] hi,
                                          input logic [31:0] es, input logic [31:0] p);
    logic [31:0] r = '0;
    for (int i = 0; i < 32; i++) begin
      logic [1:0] c = codeOf(lo, hi, i);
      if (!es[i]) r[i] = (c == 2'b00 && !p[i]) || (c == 2'b01 && p[i]);
    end
    return r;
  endfunction

  function automatic logic [31:0] edgeBits(input logic [31:0] lo, input logic [31:0] hi,
                                           input logic [31:0] es, input logic [31:0] p0,
                                           input logic [31:0] p1);
    logic [31:0] r = '0;
    for (int i = 0; i < 32; i++) begin
      logic [1:0] c = codeOf(lo, hi, i);
      if (es[i])            r[i] = p0[i] ^ p1[i];
      else if (c == 2'b10)  r[i] = !p0[i] && p1[i];
      else if (c == 2'b11)  r[i] = p0[i] && !p1[i];
    end
    return r;
  endfunction

  // R4 R5 R6 R7 R10: one sweep step over two pad words
  task automatic runScenario(input logic [31:0] lo, input logic [31:0] hi, input logic [31:0] es,
                             input logic [31:0] p0, input logic [31:0] p1, input string req);
    logic [31:0] eM0, eM1, eM2, eL0, eL1, eL2;
    eM0 = lvlBits(lo, hi, es, p0);
    eL0 = lvlBits(lo, hi, '0, p0);
    eM1 = eM0 | lvlBits(lo, hi, es, p1) | edgeBits(lo, hi, es, p0, p1);
    eL1 = eL0 | lvlBits(lo, hi, '0, p1) | edgeBits(lo, hi, '0, p0, p1);
    eM2 = lvlBits(lo, hi, es, p1);
    eL2 = lvlBits(lo, hi, '0, p1);
    busWrite(5'h0C, lo);
    busWrite(5'h10, hi);
    busWrite(5'h1C, es);
    padIn = p0;
    idle(4);
    busWrite(5'h18, 32'hFFFF_FFFF);
    peek(5'h18);
    chk({req, " R7 level after clear"}, rdData, eM0);
    chk({req, " R10 legacy after clear"}, rdDataL, eL0);
    padIn = p1;
    idle(3);
    peek(5'h18);
    chk({req, " status after transition"}, rdData, eM1);
    chk({req, " R10 legacy after transition"}, rdDataL, eL1);
    busWrite(5'h18, 32'h0);
    peek(5'h18);
    chk("R6 write zero keeps status", rdData, eM1);
    busWrite(5'h18, 32'hFFFF_FFFF);
    peek(5'h18);
    chk("R7 edges cleared, levels reassert", rdData, eM2);
    chk("R7 legacy edges cleared", rdDataL, eL2);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #(64'd200000 * 8);
    fails++;
    $display("FAIL watchdog (all requirements): actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    rstN = 1'b0; wrEn = 1'b0; addr = '0; wrData = '0; padIn = '0;
    idle(2);
    // R1: reset state
    for (int a = 0; a < 8; a++) begin
      peek(5'(a * 4));
      chk("R1 register zero in reset", rdData, 32'h0);
    end
    chk("R1 padOut in reset", padOut, 32'h0);
    chk("R1 padOe in reset", padOe, 32'h0);
    chk("R1 irq in reset", {31'h0, irqOut}, 32'h0);
    rstN = 1'b1;
    idle(2);
    chk("R1 irq masked after reset", {31'h0, irqOut}, 32'h0);
    peek(5'h0C);
    chk("R1 trigger code zero after reset", rdData, 32'h0);

    // R2: data, direction, mask
    busWrite(5'h00, 32'hA5A5_5A5A);
    busWrite(5'h04, 32'hFFFF_0000);
    busWrite(5'h14, 32'h1234_5678);
    peek(5'h00); chk("R2 data readback", rdData, 32'hA5A5_5A5A);
    peek(5'h04); chk("R2 dir readback", rdData, 32'hFFFF_0000);
    peek(5'h14); chk("R2 mask readback", rdData, 32'h1234_5678);
    chk("R2 padOut follows data", padOut, 32'hA5A5_5A5A);
    chk("R2 padOe follows dir", padOe, 32'hFFFF_0000);
    busWrite(5'h01, 32'h0000_0001);
    peek(5'h00); chk("R2 misaligned write ignored", rdData, 32'hA5A5_5A5A);
    peek(5'h01); chk("R2 misaligned read zero", rdData, 32'h0);
    busWrite(5'h14, 32'h0);

    // R3: pad status two-stage delay
    padIn = 32'hDEAD_BEEF;
    idle(1);
    peek(5'h08); chk("R3 pad status not yet", rdData, 32'h0);
    idle(1);
    peek(5'h08); chk("R3 pad status after two edges", rdData, 32'hDEAD_BEEF);

    // R4: every uniform code, two pad pairs each
    for (int c = 0; c < 4; c++) begin
      logic [31:0] rep = {16{2'(c)}};
      runScenario(rep, rep, 32'h0, 32'h0F0F_3C3C, 32'h33CC_A55A, "R4 uniform code");
      runScenario(rep, rep, 32'h0, 32'hFFFF_0000, 32'h00FF_FF00, "R4 uniform code alt");
    end
    // R4: per-pin field positions across both halves
    runScenario(32'hE4E4_E4E4, 32'h1B1B_1B1B, 32'h0, 32'h0000_0000, 32'hFFFF_FFFF, "R4 mixed rise");
    runScenario(32'hE4E4_E4E4, 32'h1B1B_1B1B, 32'h0, 32'hFFFF_FFFF, 32'h0000_0000, "R4 mixed fall");
    runScenario(32'h1B1B_1B1B, 32'hE4E4_E4E4, 32'h0, 32'h5A5A_C3C3, 32'hA5A5_3C3C, "R4 mixed swap");
    // R5: edge select overrides codes
    runScenario(32'hAAAA_AAAA, 32'hAAAA_AAAA, 32'hFF00_F0F0, 32'h0000_FFFF, 32'hFFFF_0000, "R5 edge sel over rise");
    runScenario(32'h0000_0000, 32'h5555_5555, 32'hFFFF_FFFF, 32'h1234_5678, 32'h8765_4321, "R5 edge sel over level");
    runScenario(32'hFFFF_FFFF, 32'h0000_0000, 32'h0F0F_0F0F, 32'hCCCC_CCCC, 32'h3333_3333, "R5 edge sel mixed");
    peek(5'h1C);
    chk("R5 edge select readback", rdData, 32'h0F0F_0F0F);

    // R8: set beats clear in the same cycle
    busWrite(5'h0C, 32'hAAAA_AAAA);
    busWrite(5'h10, 32'hAAAA_AAAA);
    busWrite(5'h1C, 32'h0);
    padIn = 32'h0;
    idle(4);
    busWrite(5'h18, 32'hFFFF_FFFF);
    peek(5'h18); chk("R8 clean before collision", rdData, 32'h0);
    padIn = 32'h0000_00FF;
    idle(2);
    busWrite(5'h18, 32'hFFFF_FFFF);
    peek(5'h18); chk("R8 set wins over clear", rdData, 32'h0000_00FF);
    chk("R8 legacy set wins", rdDataL, 32'h0000_00FF);

    // R9: interrupt combine
    chk("R9 masked irq low", {31'h0, irqOut}, 32'h0);
    busWrite(5'h14, 32'h0000_0100);
    chk("R9 mask on idle bit", {31'h0, irqOut}, 32'h0);
    busWrite(5'h14, 32'h0000_0001);
    chk("R9 mask on set bit", {31'h0, irqOut}, 32'h1);
    busWrite(5'h18, 32'h0000_0001);
    chk("R9 irq drops after clear", {31'h0, irqOut}, 32'h0);
    busWrite(5'h14, 32'h0);

    // R10: legacy edge register absent
    busWrite(5'h1C, 32'hFFFF_FFFF);
    peek(5'h1C);
    chk("R10 legacy edge reg reads zero", rdDataL, 32'h0);
    chk("R5 edge reg present in default build", rdData, 32'hFFFF_FFFF);

    summary();
    $finish;
  end

endmodule